// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

A programmable countdown timer that sits beside a local interrupt controller. Software programs an initial count, a divide setting and a control word holding the vector, a mask bit and a periodic-mode bit. A power-of-two prescaler turns the system clock into count ticks. The current count falls by one on every tick. When the schedule expires, the block raises a one-cycle request that carries the programmed vector. Routing that request into the priority logic is left to the surrounding controller.

In one-shot mode the count stops at zero and the block raises a single request. In periodic mode the count reloads after reaching zero, so it repeats every initial-count-plus-one ticks. Masking silences the requests but leaves counting running. Unmasking therefore picks up the schedule set by the last load.

Software uses a simple word-wide register port: a write strobe with address and data, and a combinational read selected by a separate address. The address map is: 0 = control word, 1 = initial count, 2 = current count (read only), 3 = divide setting.

Top module: `local_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (only the mask bit set). The initial count, current count and divide setting read zero, and no request is raised.
- R2: The divide setting keeps only bits 3, 1 and 0 of a write; all other bits read back as zero.
- R3: The divider index is {bit3, bit1, bit0} of the divide setting. A tick occurs every 2^((index+1) mod 8) clocks, so index 7 (setting 0xB) ticks on every clock and setting 0x0 ticks every 2 clocks.
- R4: In the control word, bit 17 selects periodic mode, bit 16 masks requests and bits 7:0 hold the vector. All other bits read back as zero.
- R5: Writing the initial count sets the current count to the written value and restarts the prescaler phase in the same cycle. Without a tick or a load, the current count holds.
- R6: In one-shot mode the current count is the initial count minus the elapsed ticks, saturating at 0. Exactly one request is raised, (initial+1) ticks after the load.
- R7: In periodic mode the count reloads to the initial value on the tick after it reaches zero. A request is raised every (initial+1) ticks.
- R8: With an initial count of zero, neither mode raises any request.
- R9: While the mask bit is set, no request is raised but counting continues. After the mask is cleared, the next request arrives at the next boundary of the schedule that started at the last load.
- R10: A request is a single-cycle high on the valid output, with the programmed 8-bit vector on the vector output in the same cycle.
- R11: Writes to address 2 (current count) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | 32 | Read data (combinational) |
| expValid | output | 1 | One-cycle expiry request |
| expVector | output | 8 | Vector accompanying the request |

## Verification
Some properties are checked on every cycle by the assertions:
- a request is never longer than one cycle;
- no request follows a cycle in which the timer was masked or the initial count was zero;
- the current count never exceeds the initial count and holds between ticks and loads;
- ticks are never adjacent when the divider is above one.

Other behaviour needs the bench's scenarios:
- the exact expiry cycle for every divider index;
- the saturating one-shot count;
- the periodic reload cadence;
- resumption on the original schedule after unmasking;
- the register write masks.

// File: rtl/local_timer_pkg.sv
package local_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int VEC_W = 8;
  localparam int MAX_SHIFT = 7;
  localparam int PRE_W = MAX_SHIFT;
  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_INIT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CUR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic load;
    logic tick;
    logic periodic;
    logic masked;
  } tmrStrobe_t;
endpackage

// File: rtl/local_timer_ctrl.sv
module local_timer_ctrl
  import local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  curCount,
  output tmrStrobe_t        stb,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  initCount,
  output logic [VEC_W-1:0]  vector,
  output logic [DATA_W-1:0] rdData
);
  logic [2:0]       divKeep;
  logic             periodicReg;
  logic             maskReg;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] tickMask;
  logic [2:0]       shiftVal;
  logic             divWrite;

  assign divWrite = wrEn && (wrAddr == ADDR_DIV);
  assign shiftVal = divKeep + 3'd1;
  assign loadVal  = wrData[CNT_W-1:0];

  always_comb begin
    for (int i = 0; i < PRE_W; i++) tickMask[i] = (i < int'(shiftVal));
  end

  always_comb begin
    stb.load     = wrEn && (wrAddr == ADDR_INIT);
    stb.tick     = ((preCnt & tickMask) == tickMask);
    stb.periodic = periodicReg;
    stb.masked   = maskReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCount   <= '0;
      divKeep     <= '0;
      periodicReg <= 1'b0;
      maskReg     <= 1'b1;
      vector      <= '0;
      preCnt      <= '0;
    end else begin
      preCnt <= stb.load ? '0 : preCnt + 1'b1;
      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL: begin
            periodicReg <= wrData[PERIODIC_BIT];
            maskReg     <= wrData[MASK_BIT];
            vector      <= wrData[VEC_W-1:0];
          end
          ADDR_INIT: initCount <= wrData[CNT_W-1:0];
          ADDR_DIV:  divKeep   <= {wrData[3], wrData[1:0]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: begin
        rdData[PERIODIC_BIT] = periodicReg;
        rdData[MASK_BIT]     = maskReg;
        rdData[VEC_W-1:0]    = vector;
      end
      ADDR_INIT: rdData[CNT_W-1:0] = initCount;
      ADDR_CUR:  rdData[CNT_W-1:0] = curCount;
      default:   rdData[3:0] = {divKeep[2], 1'b0, divKeep[1:0]};
    endcase
  end

  // R3: above divide-by-one, a tick is never followed by another tick
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && shiftVal != 3'd0 && !stb.load && !divWrite) |=> !stb.tick);
endmodule

// File: rtl/local_timer_core.sv
module local_timer_core
  import local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initCount,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] curCount,
  output logic             expValid,
  output logic [VEC_W-1:0] expVector
);
  logic armed;
  logic atZero;
  logic fire;

  assign atZero = (curCount == '0);
  assign fire = stb.tick && atZero &&
                (stb.periodic ? (initCount != '0) : armed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount  <= '0;
      armed     <= 1'b0;
      expValid  <= 1'b0;
      expVector <= '0;
    end else begin
      expValid <= !stb.load && fire && !stb.masked;
      if (!stb.load && fire) expVector <= vector;
      if (stb.load) begin
        curCount <= loadVal;
        armed    <= (loadVal != '0);
      end else if (stb.tick) begin
        if (atZero) begin
          curCount <= stb.periodic ? initCount : '0;
          if (!stb.periodic) armed <= 1'b0;
        end else begin
          curCount <= curCount - 1'b1;
        end
      end
    end
  end

  // R10: a request lasts exactly one cycle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    expValid |=> !expValid);
  // R9: no request when the mask was set at the expiry edge
  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    expValid |-> !$past(stb.masked));
  // R8: a zero initial count never expires
  p_zero_init_r8: assert property (@(posedge clk) disable iff (!rstN)
    expValid |-> ($past(initCount) != '0));
  // R6: the count never exceeds the programmed start value
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    curCount <= initCount);
  // R5: count holds when neither tick nor load
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.tick) |=> $stable(curCount));
endmodule

// File: rtl/local_timer.sv
module local_timer
  import local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        expValid,
  output logic [7:0]  expVector
);
  tmrStrobe_t       stb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] initCount;
  logic [CNT_W-1:0] curCount;
  logic [VEC_W-1:0] vector;

  local_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .curCount(curCount), .stb(stb), .loadVal(loadVal),
    .initCount(initCount), .vector(vector), .rdData(rdData)
  );

  local_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(loadVal),
    .initCount(initCount), .vector(vector), .curCount(curCount),
    .expValid(expValid), .expVector(expVector)
  );
endmodule

// File: tb/local_timer_bench.sv
module local_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 8;
  // {divide setting, initial count, expected clocks from load to request}
  localparam logic [67:0] TAB [NTAB] = '{
    {4'hB, 32'd5, 32'd6},   {4'h0, 32'd3, 32'd8},
    {4'h1, 32'd2, 32'd12},  {4'h2, 32'd1, 32'd16},
    {4'h3, 32'd1, 32'd32},  {4'h8, 32'd2, 32'd96},
    {4'h9, 32'd1, 32'd128}, {4'hA, 32'd1, 32'd256}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic expValid;
  logic [7:0] expVector;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int pulseCnt = 0;
  int firstPulse = 0;
  logic [7:0] lastVec = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  local_timer u_local_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .expValid(expValid), .expVector(expVector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (expValid) begin
      if (pulseCnt == 0) firstPulse = cyc;
      pulseCnt++;
      lastVec = expVector;
    end
  endtask

  task automatic clrMon();
    pulseCnt = 0;
    firstPulse = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic runTo(input int t);
    while (cyc < t) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int L;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk(expValid == 1'b0, "R1 no request", {31'b0, expValid}, 0);
    rd(2'd0, v); chk(v == 32'h0001_0000, "R1 control", v, 32'h0001_0000);
    rd(2'd1, v); chk(v == 0, "R1 initial", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 current", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 divide", v, 0);

    // R2 divide mask, R4 control fields
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk(v == 32'hB, "R2 divide mask", v, 32'hB);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'h0003_00FF, "R4 control fields", v, 32'h0003_00FF);

    // Table: R3 divider, R6 one-shot timing, R10 vector
    for (int i = 0; i < NTAB; i++) begin
      logic [3:0] dv;
      logic [31:0] ic, ex;
      dv = TAB[i][67:64]; ic = TAB[i][63:32]; ex = TAB[i][31:0];
      wr(2'd0, 32'h40 + 32'(i));
      wr(2'd3, {28'b0, dv});
      clrMon();
      wr(2'd1, ic);
      L = cyc;
      runTo(L + int'(ex) + 6);
      chk(firstPulse - L == int'(ex), "R3 expiry cycle", 32'(firstPulse - L), ex);
      chk(pulseCnt == 1, "R6 single request", 32'(pulseCnt), 1);
      chk(lastVec == 8'(8'h40 + i), "R10 vector", {24'b0, lastVec}, 32'h40 + 32'(i));
    end

    // R6 saturating count, divide by one
    wr(2'd0, 32'h0000_0021);
    wr(2'd3, 32'hB);
    clrMon();
    wr(2'd1, 32'd10);
    L = cyc;
    runTo(L + 3);
    rd(2'd2, v); chk(v == 7, "R6 count after 3 ticks", v, 7);
    runTo(L + 15);
    rd(2'd2, v); chk(v == 0, "R6 saturated count", v, 0);
    chk(pulseCnt == 1, "R6 one request", 32'(pulseCnt), 1);
    chk(firstPulse - L == 11, "R6 request time", 32'(firstPulse - L), 11);

    // R7 periodic cadence and reload
    wr(2'd0, 32'h0002_0033);
    clrMon();
    wr(2'd1, 32'd3);
    L = cyc;
    runTo(L + 4);
    rd(2'd2, v); chk(v == 3, "R7 reload value", v, 3);
    chk(pulseCnt == 1 && firstPulse - L == 4, "R7 first period",
        32'(firstPulse - L), 4);
    runTo(L + 21);
    chk(pulseCnt == 5, "R7 request count", 32'(pulseCnt), 5);

    // R8 zero initial count in both modes
    clrMon();
    wr(2'd1, 32'd0);
    runTo(cyc + 30);
    chk(pulseCnt == 0, "R8 periodic zero", 32'(pulseCnt), 0);
    wr(2'd0, 32'h0000_0033);
    clrMon();
    wr(2'd1, 32'd0);
    runTo(cyc + 30);
    chk(pulseCnt == 0, "R8 one-shot zero", 32'(pulseCnt), 0);

    // R9 mask silences, unmask resumes original schedule
    wr(2'd0, 32'h0003_0044);
    clrMon();
    wr(2'd1, 32'd3);
    L = cyc;
    runTo(L + 10);
    chk(pulseCnt == 0, "R9 masked silent", 32'(pulseCnt), 0);
    wr(2'd0, 32'h0002_0044);
    runTo(L + 30);
    chk(firstPulse - L == 12, "R9 resume on schedule", 32'(firstPulse - L), 12);
    chk(pulseCnt == 5, "R9 requests after unmask", 32'(pulseCnt), 5);
    chk(lastVec == 8'h44, "R10 vector periodic", {24'b0, lastVec}, 32'h44);

    // R5 reload restarts, R11 current-count write ignored
    wr(2'd0, 32'h0001_0000);
    wr(2'd1, 32'd100);
    L = cyc;
    runTo(L + 5);
    rd(2'd2, v); chk(v == 95, "R5 count after load", v, 95);
    wr(2'd2, 32'h55);
    rd(2'd2, v); chk(v == 94, "R11 write ignored", v, 94);
    wr(2'd1, 32'd40);
    rd(2'd2, v); chk(v == 40, "R5 reload restarts", v, 40);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule